// File: doc/BRIEF.md
# Row-Granular Write Protection Controller

This block decides, for a serial memory of 256 bytes, whether each access from the bus front end may go ahead. It holds an 8-bit protection setting and a write-control level. From these two inputs it grants or refuses writes to the array, writes to the setting itself, and reads of the setting. The front end turns a grant into an acknowledge and a refusal into a no-acknowledge. Array reads are always granted.

The array is split into rows of 16 bytes. The low seven bits of the setting are a row pointer, and bit 7 chooses which side of that pointer is locked. The lower zone is the first `pointer` rows; the upper zone is all rows above them. Protection applies only while write-control is high. A write-control pin that nobody drives counts as high.

The setting leaves reset as 00h and marked unprogrammed. In that state it accepts exactly one write, whatever the write-control level. Once any value has been written, even 00h, it can change again only while write-control is low. The write-cycle sequencer loads new values through a separate update port.

Top module: `wprot_ctrl`

## Requirements
- R1: After reset the setting reads 00h, it is unprogrammed, and `resp_valid` is low.
- R2: Row index is `req_addr[7:4]`, and the effective pointer p is bits 6..0 of the setting, clamped to 16. With bit 7 = 0 and write-control high, array writes to rows whose index is below p are refused. A value of p = 0 locks nothing, and p = 16 locks everything.
- R3: With bit 7 = 1 and write-control high, array writes to rows whose index is p or more are refused. A value of p = 0 locks the whole array.
- R4: While write-control is low, every array write and every write of the setting is granted.
- R5: When `wc_drv` = 0, write-control counts as high whatever `wc_lvl` holds.
- R6: While unprogrammed, a write of the setting is granted and an update is applied even with write-control high. After any applied update, including 00h, the setting is programmed. From then on, with write-control high, setting writes are refused and updates leave the setting unchanged.
- R7: A read of the setting (`req_tgt` = 1, `req_wr` = 0) is granted only while write-control is low. `resp_rdata` then carries the setting, and otherwise carries 00h.
- R8: Array reads (`req_tgt` = 0, `req_wr` = 0) are always granted, whatever the setting and write-control.
- R9: The address sent with a setting write has no effect on the grant. The update data byte becomes the new setting in full, bit 7 included.
- R10: A request sampled at a clock edge produces `resp_valid` = 1 with its grant on the following edge. `resp_valid` is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wc_lvl | input | 1 | Level on the write-control pin |
| wc_drv | input | 1 | 1 when the write-control pin is driven |
| req_valid | input | 1 | Request strobe from the front end |
| req_tgt | input | 1 | 0 = array, 1 = protection setting |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address of the request |
| upd_en | input | 1 | Update strobe from the write-cycle sequencer |
| upd_data | input | 8 | New setting value |
| resp_valid | output | 1 | Response strobe, one cycle after the request |
| resp_allow | output | 1 | 1 = grant (acknowledge), 0 = refuse |
| resp_rdata | output | 8 | Setting value for granted setting reads, else 00h |

## Verification
On every cycle the assertions check several things. The programmed mark never clears once set. A refused update leaves the setting unchanged. Any request made while write-control is low is answered with a grant. Array reads are always granted, and a granted setting read only follows a cycle with write-control low. The assertions cannot show where the row boundaries fall for a given pointer and top/bottom bit, how pointer values above 16 are clamped, or that the one-time write is spent even by 00h. Only the bench's table and directed scenarios, with hand-computed expected grants, show those.

// File: rtl/wprot_pkg.sv
// Shared types for the write protection controller.
package wprot_pkg;
    // Request target encoding.
    typedef enum logic {
        TGT_ARRAY = 1'b0,
        TGT_SETTING = 1'b1
    } tgt_e;

    // Layout of the protection setting: a side select above a row pointer.
    typedef struct packed {
        logic       top_sel;
        logic [6:0] row_ptr;
    } prot_set_t;
endpackage

// File: rtl/wprot_store.sv
// Holds the protection setting and its sticky programmed mark.
// Assumes: upd_en comes from the write-cycle sequencer; wc_high is already
// resolved (undriven counts as high). Non-volatile cells modelled as flops.
module wprot_store
    import wprot_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wc_high,
    input  logic      upd_en,
    input  logic [7:0] upd_data,
    output prot_set_t setting,
    output logic      programmed
);
    logic upd_ok;

    // An update lands when write-control is low or the one-time write is unused.
    always_comb upd_ok = upd_en && (!wc_high || !programmed);

    // Setting register and programmed mark, both reset to delivery state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            setting    <= '0;
            programmed <= 1'b0;
        end else if (upd_ok) begin
            setting    <= prot_set_t'(upd_data);
            programmed <= 1'b1;
        end
    end

    assert_mark_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        programmed |=> programmed);

    assert_locked_update_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && wc_high && programmed) |=> $stable(setting));

    assert_update_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !wc_high) |=> (setting == $past(upd_data)));
endmodule

// File: rtl/wprot_zone.sv
// Maps a byte address to locked/unlocked for the array from the setting.
// Assumes: rows of 2**OFFS_W bytes; pointer values above the row count clamp.
module wprot_zone
    import wprot_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int OFFS_W = 4,
    parameter int PTR_W  = 7
) (
    input  prot_set_t          setting,
    input  logic [ADDR_W-1:0]  addr,
    output logic               locked
);
    localparam int ROWS  = 2 ** (ADDR_W - OFFS_W);
    localparam int ROW_W = ADDR_W - OFFS_W;

    logic [PTR_W-1:0] ptr_c;
    logic [ROWS-1:0]  below;
    logic [ROW_W-1:0] row;

    // Clamp the pointer so oversize values mean "all rows".
    always_comb ptr_c = (setting.row_ptr > PTR_W'(ROWS)) ? PTR_W'(ROWS) : setting.row_ptr;

    // One comparator per row: row i belongs to the lower zone when i < pointer.
    for (genvar i = 0; i < ROWS; i++) begin : g_row
        always_comb below[i] = (PTR_W'(i) < ptr_c);
    end

    // Select the row, then the side chosen by top_sel.
    always_comb begin
        row    = addr[ADDR_W-1:OFFS_W];
        locked = setting.top_sel ? !below[row] : below[row];
    end
endmodule

// File: rtl/wprot_decide.sv
// Combines target, direction, write-control and zone into a grant.
// Assumes: all inputs settled in the same cycle; purely combinational.
module wprot_decide
    import wprot_pkg::*;
(
    input  tgt_e tgt,
    input  logic wr,
    input  logic wc_high,
    input  logic zone_locked,
    input  logic programmed,
    output logic allow,
    output logic show_setting
);
    // Grant table per target and direction.
    always_comb begin
        show_setting = 1'b0;
        if (tgt == TGT_ARRAY) begin
            allow = wr ? (!wc_high || !zone_locked) : 1'b1;
        end else if (wr) begin
            allow = !wc_high || !programmed;
        end else begin
            allow        = !wc_high;
            show_setting = !wc_high;
        end
    end
endmodule

// File: rtl/wprot_ctrl.sv
// Top of the write protection controller: resolves write-control, decodes
// the zone and registers one response per request.
// Assumes: the front end holds request fields stable in the strobe cycle.
module wprot_ctrl
    import wprot_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int OFFS_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wc_lvl,
    input  logic              wc_drv,
    input  logic              req_valid,
    input  logic              req_tgt,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              upd_en,
    input  logic [DATA_W-1:0] upd_data,
    output logic              resp_valid,
    output logic              resp_allow,
    output logic [DATA_W-1:0] resp_rdata
);
    localparam int PTR_W = DATA_W - 1;

    logic      wc_high;
    prot_set_t setting;
    logic      programmed;
    logic      zone_locked;
    logic      allow_c;
    logic      show_c;

    // Undriven pin reads as high.
    always_comb wc_high = !wc_drv || wc_lvl;

    wprot_store i_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wc_high    (wc_high),
        .upd_en     (upd_en),
        .upd_data   (upd_data),
        .setting    (setting),
        .programmed (programmed)
    );

    wprot_zone #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .PTR_W(PTR_W)) i_zone (
        .setting (setting),
        .addr    (req_addr),
        .locked  (zone_locked)
    );

    wprot_decide i_decide (
        .tgt          (tgt_e'(req_tgt)),
        .wr           (req_wr),
        .wc_high      (wc_high),
        .zone_locked  (zone_locked),
        .programmed   (programmed),
        .allow        (allow_c),
        .show_setting (show_c)
    );

    // Response register: one strobe per request, data only for granted setting reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_allow <= 1'b0;
            resp_rdata <= '0;
        end else begin
            resp_valid <= req_valid;
            resp_allow <= req_valid && allow_c;
            resp_rdata <= (req_valid && show_c) ? DATA_W'(setting) : '0;
        end
    end

    assert_resp_follows_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);

    assert_no_stray_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid);

    assert_wc_low_grants_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !wc_high) |=> resp_allow);

    assert_array_read_granted_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_tgt && !req_wr) |=> resp_allow);

    assert_setting_read_needs_wc_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_tgt && !req_wr && wc_high) |=> (!resp_allow && resp_rdata == '0));
endmodule

// File: tb/test_wprot_ctrl.sv
`timescale 1ns/1ps
module test_wprot_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       wc_lvl, wc_drv;
    logic       req_valid, req_tgt, req_wr;
    logic [7:0] req_addr;
    logic       upd_en;
    logic [7:0] upd_data;
    logic       resp_valid, resp_allow;
    logic [7:0] resp_rdata;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    wprot_ctrl i_wprot_ctrl (
        .clk(clk), .rst_n(rst_n), .wc_lvl(wc_lvl), .wc_drv(wc_drv),
        .req_valid(req_valid), .req_tgt(req_tgt), .req_wr(req_wr), .req_addr(req_addr),
        .upd_en(upd_en), .upd_data(upd_data),
        .resp_valid(resp_valid), .resp_allow(resp_allow), .resp_rdata(resp_rdata)
    );

    // Vector: {wc_lvl, wc_drv, tgt, wr, addr[7:0], exp_allow}, setting = 03h, programmed.
    localparam logic [12:0] VEC [12] = '{
        {4'b1101, 8'h00, 1'b0},   // R2 row 0 locked
        {4'b1101, 8'h2F, 1'b0},   // R2 row 2 locked
        {4'b1101, 8'h30, 1'b1},   // R2 row 3 free
        {4'b1101, 8'hFF, 1'b1},   // R2 top free
        {4'b0101, 8'h00, 1'b1},   // R4 wc low
        {4'b1001, 8'h10, 1'b0},   // R5 undriven, level high
        {4'b0001, 8'h10, 1'b0},   // R5 undriven, level low
        {4'b1100, 8'h00, 1'b1},   // R8 array read
        {4'b1111, 8'h55, 1'b0},   // R6 setting write locked
        {4'b0111, 8'h55, 1'b1},   // R4 setting write wc low
        {4'b1110, 8'h00, 1'b0},   // R7 setting read wc high
        {4'b0110, 8'h00, 1'b1}    // R7 setting read wc low
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0; upd_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One request; returns the response sampled one edge later.
    task automatic do_req(input logic lvl, input logic drv, input logic tgt, input logic wr,
                          input logic [7:0] addr, output logic v, output logic al, output logic [7:0] rd);
        @(negedge clk);
        wc_lvl = lvl; wc_drv = drv; req_tgt = tgt; req_wr = wr; req_addr = addr; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        v = resp_valid; al = resp_allow; rd = resp_rdata;
    endtask

    task automatic do_upd(input logic lvl, input logic [7:0] d);
        @(negedge clk);
        wc_lvl = lvl; wc_drv = 1'b1; upd_en = 1'b1; upd_data = d;
        @(negedge clk);
        upd_en = 1'b0;
    endtask

    task automatic read_setting(input string req, input logic [7:0] exp);
        logic v, al;
        logic [7:0] rd;
        do_req(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, v, al, rd);
        check(req, rd, exp);
    endtask

    task automatic arr_wr(input string req, input logic [7:0] addr, input logic exp);
        logic v, al;
        logic [7:0] rd;
        do_req(1'b1, 1'b1, 1'b0, 1'b1, addr, v, al, rd);
        check(req, {7'd0, al}, {7'd0, exp});
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic v, al;
        logic [7:0] rd;
        wc_lvl = 1'b1; wc_drv = 1'b1; req_valid = 1'b0; req_tgt = 1'b0; req_wr = 1'b0;
        req_addr = '0; upd_en = 1'b0; upd_data = '0; rst_n = 1'b0;
        do_reset();

        // R1 reset state
        check("R1 resp_valid", {7'd0, resp_valid}, 8'h00);
        read_setting("R1 setting", 8'h00);
        // R10 idle cycle gives no response
        @(negedge clk);
        check("R10 idle", {7'd0, resp_valid}, 8'h00);

        // R6 one-time write with wc high; address ignored (R9)
        do_req(1'b1, 1'b1, 1'b1, 1'b1, 8'hC3, v, al, rd);
        check("R6 virgin grant", {7'd0, al}, 8'h01);
        check("R10 strobe", {7'd0, v}, 8'h01);
        do_upd(1'b1, 8'h03);
        read_setting("R9 setting 03", 8'h03);
        do_upd(1'b1, 8'hAA);
        read_setting("R6 update ignored", 8'h03);

        // Table walk with setting 03h
        foreach (VEC[k]) begin
            do_req(VEC[k][12], VEC[k][11], VEC[k][10], VEC[k][9], VEC[k][8:1], v, al, rd);
            check($sformatf("R2-R8 vec%0d", k), {7'd0, al}, {7'd0, VEC[k][0]});
        end

        // R3 bit 7 set, pointer 3
        do_upd(1'b0, 8'h83);
        read_setting("R9 setting 83", 8'h83);
        arr_wr("R3 row2 free", 8'h20, 1'b1);
        arr_wr("R3 row3 locked", 8'h30, 1'b0);
        // R3 pointer 0 locks all
        do_upd(1'b0, 8'h80);
        arr_wr("R3 all locked", 8'h00, 1'b0);
        // R2 clamp: 7Fh locks all
        do_upd(1'b0, 8'h7F);
        arr_wr("R2 clamp bottom", 8'hFF, 1'b0);
        // R3 clamp: FFh locks nothing
        do_upd(1'b0, 8'hFF);
        arr_wr("R3 clamp top", 8'h00, 1'b1);
        // R2 pointer 0 bottom locks nothing
        do_upd(1'b0, 8'h00);
        arr_wr("R2 ptr0 free", 8'h00, 1'b1);

        // R6 programming with 00h also spends the one-time write
        do_reset();
        do_upd(1'b1, 8'h00);
        do_req(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, v, al, rd);
        check("R6 00h spends", {7'd0, al}, 8'h00);
        do_upd(1'b1, 8'h85);
        read_setting("R6 locked after 00h", 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule